// File: doc/BRIEF.md
# Dual Retriggerable Gated One-Shot

This block holds two independent one-shot pulse channels. Each channel watches three level inputs: an active-low gate/trigger, an active-high gate/trigger and an active-low clear. When one of three gated edge conditions is seen, the channel drives its true output high for a programmed number of clock cycles. A complementary output follows in antiphase. The pulse length comes from a per-channel cycle count, so no external timing network is needed.

All three inputs of a channel are asynchronous. Each passes through a two-flop synchronizer before edges are detected. A new qualified edge during a pulse reloads the full count, so triggers that arrive often enough hold the output high with no gap. While the clear is low, the pulse is cut off and further triggers are ignored.

Top module: `dual_oneshot`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every `q` is 0 and every `q_n` is 1.
- R2: A rising edge on `trig_b` while `trig_a_n` is low starts a pulse. `q` goes high at the third clock edge after the input change: two synchronizer stages plus one output register.
- R3: A falling edge on `trig_a_n` while `trig_b` is high starts a pulse, with the same latency as R2.
- R4: A rising edge on `clr_n` while `trig_a_n` is low and `trig_b` is high starts a pulse, with the same latency as R2.
- R5: A pulse holds `q` high for exactly the count in the channel's `dur` field, read when the trigger is taken. Channel k uses bits [k*16 +: 16].
- R6: A qualified edge during an active pulse reloads the full count. The pulse then ends exactly `dur` cycles after the most recent trigger.
- R7: A low `clr_n` drives `q` low three edges after it is applied. It blocks all triggers for as long as it stays low.
- R8: If a qualified trigger edge and a low clear reach the channel in the same cycle, the clear wins and `q` stays low.
- R9: A count of zero produces no pulse at all.
- R10: `q_n` is always the complement of `q`.
- R11: The two channels are independent: stimulus on one channel never changes the other channel's outputs.
- R12: Edges that do not meet a gate condition start no pulse. This covers `trig_b` rising while `trig_a_n` is high, and `trig_a_n` falling while `trig_b` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_a_n | input | NCH | Active-low trigger/gate, one bit per channel, asynchronous |
| trig_b | input | NCH | Active-high trigger/gate, one bit per channel, asynchronous |
| clr_n | input | NCH | Active-low clear, one bit per channel, asynchronous |
| dur | input | NCH*DUR_W | Pulse length in cycles, DUR_W bits per channel |
| q | output | NCH | True pulse output per channel |
| q_n | output | NCH | Complementary pulse output per channel |

## Verification
Two events can meet in the same cycle. A trigger edge can coincide with the clear going low, and a retrigger can land on the last high cycle of a running pulse. The bench provokes the first by raising `trig_b` and dropping `clr_n` in the same cycle. It expects `q` to stay low. It provokes the second by pulsing `trig_b` at intervals shorter than the programmed count. There it expects `q` to stay high and then fall exactly one count after the last edge. A reference model, running on the driven input history, queues the expected `q` for each cycle, and a monitor compares both outputs against it.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  // Synchronized view of one channel's control inputs
  typedef struct packed {
    logic a_n;    // active-low trigger/gate
    logic b;      // active-high trigger/gate
    logic clr_n;  // active-low clear
  } trig_in_t;

  localparam int TRIG_W = $bits(trig_in_t);
  // Idle level of the inputs: a_n high, b low, clear released
  localparam trig_in_t TRIG_IDLE = '{a_n: 1'b1, b: 1'b0, clr_n: 1'b1};
endpackage

// File: rtl/os_sync2.sv
module os_sync2 #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/os_edge_qual.sv
module os_edge_qual
  import oneshot_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  trig_in_t cur,
  output logic     fire,
  output logic     clr_low
);
  trig_in_t prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= TRIG_IDLE;
    else     prev <= cur;
  end

  logic b_rise, a_fall, clr_rise;

  always_comb begin
    b_rise   = cur.b & ~prev.b & ~cur.a_n;
    a_fall   = prev.a_n & ~cur.a_n & cur.b;
    clr_rise = cur.clr_n & ~prev.clr_n & ~cur.a_n & cur.b;
    clr_low  = ~cur.clr_n;
    fire     = b_rise | a_fall | clr_rise;
  end
endmodule

// File: rtl/os_pulse_timer.sv
module os_pulse_timer #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             clr_low,
  input  logic [DUR_W-1:0] dur,
  output logic             q,
  output logic             q_n
);
  logic [DUR_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst || clr_low) begin
      remain <= '0;
      q      <= 1'b0;
      q_n    <= 1'b1;
    end else if (fire) begin
      remain <= dur;
      q      <= (dur != '0);
      q_n    <= (dur == '0);
    end else if (remain > DUR_W'(1)) begin
      remain <= remain - DUR_W'(1);
    end else begin
      remain <= '0;
      q      <= 1'b0;
      q_n    <= 1'b1;
    end
  end
endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot
  import oneshot_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int DUR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       trig_a_n,
  input  logic [NCH-1:0]       trig_b,
  input  logic [NCH-1:0]       clr_n,
  input  logic [NCH*DUR_W-1:0] dur,
  output logic [NCH-1:0]       q,
  output logic [NCH-1:0]       q_n
);
  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_chan
      trig_in_t raw_in, sync_in;
      logic     fire, clr_low;

      assign raw_in = '{a_n: trig_a_n[ch], b: trig_b[ch], clr_n: clr_n[ch]};

      os_sync2 #(.W(TRIG_W), .RST_VAL(TRIG_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_in)
      );

      os_edge_qual u_qual (
        .clk     (clk),
        .rst     (rst),
        .cur     (sync_in),
        .fire    (fire),
        .clr_low (clr_low)
      );

      os_pulse_timer #(.DUR_W(DUR_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .clr_low (clr_low),
        .dur     (dur[ch*DUR_W +: DUR_W]),
        .q       (q[ch]),
        .q_n     (q_n[ch])
      );
    end
  endgenerate
endmodule

// File: rtl/dual_oneshot_chk.sv
module dual_oneshot_chk #(
  parameter int NCH   = 2,
  parameter int DUR_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NCH-1:0]       trig_a_n,
  input logic [NCH-1:0]       trig_b,
  input logic [NCH-1:0]       clr_n,
  input logic [NCH*DUR_W-1:0] dur,
  input logic [NCH-1:0]       q,
  input logic [NCH-1:0]       q_n
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_chk
      // R10: outputs are always complementary
      p_complement_r10: assert property (@(posedge clk) disable iff (rst)
        q[ch] != q_n[ch]);

      // R1: outputs idle right after a reset cycle
      always @(posedge clk) begin
        if (rst_d === 1'b1)
          p_reset_idle_r1: assert (!q[ch] && q_n[ch]);
      end

      // R7: a clear low three edges back forces q low
      p_clear_cut_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst, 3) && $past(!clr_n[ch], 3)) |-> !q[ch]);

      // R12 (also R2, R3, R4): q only rises after a qualified raw edge
      p_qualified_start_r12: assert property (@(posedge clk) disable iff (rst)
        ($rose(q[ch]) && $past(!rst, 4)) |->
          (($past(trig_b[ch], 3) && !$past(trig_b[ch], 4) && !$past(trig_a_n[ch], 3)) ||
           (!$past(trig_a_n[ch], 3) && $past(trig_a_n[ch], 4) && $past(trig_b[ch], 3)) ||
           ($past(clr_n[ch], 3) && !$past(clr_n[ch], 4) &&
            !$past(trig_a_n[ch], 3) && $past(trig_b[ch], 3))));

      // R9: a pulse never starts from a zero count
      p_zero_len_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(q[ch]) && $past(!rst, 1)) |-> ($past(dur[ch*DUR_W +: DUR_W], 1) != '0));
    end
  endgenerate
endmodule

bind dual_oneshot dual_oneshot_chk #(.NCH(NCH), .DUR_W(DUR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .trig_a_n (trig_a_n),
  .trig_b   (trig_b),
  .clr_n    (clr_n),
  .dur      (dur),
  .q        (q),
  .q_n      (q_n)
);

// File: tb/dual_oneshot_bench.sv
`timescale 1ns/1ps
module dual_oneshot_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 2;
  localparam int DUR_W = 16;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NCH-1:0]       trig_a_n = '1;
  logic [NCH-1:0]       trig_b   = '0;
  logic [NCH-1:0]       clr_n    = '1;
  logic [NCH*DUR_W-1:0] dur      = '0;
  logic [NCH-1:0]       q, q_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_oneshot #(.NCH(NCH), .DUR_W(DUR_W)) u_dual_oneshot (
    .clk(clk), .rst(rst), .trig_a_n(trig_a_n), .trig_b(trig_b),
    .clr_n(clr_n), .dur(dur), .q(q), .q_n(q_n)
  );

  typedef struct {
    int    tag;
    int    ch;
    logic  q;
    string req;
  } exp_t;

  exp_t  sb[$];
  int    checks = 0;
  int    errors = 0;
  int    cyc    = 0;
  bit    started = 0;
  bit    done    = 0;
  string phase  = "R1";

  // reference state per channel
  int             m_cnt [NCH];
  logic [NCH-1:0] pa_n = '1, pb = '0, pclr = '1;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare due expectations at the falling edge
  always @(negedge clk) begin
    if (started) begin
      while (sb.size() > 0 && sb[0].tag <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (e.tag < cyc) begin
          errors++;
          $display("FAIL %s ch%0d stale expectation tag=%0d cyc=%0d", e.req, e.ch, e.tag, cyc);
        end else if (q[e.ch] !== e.q || q_n[e.ch] !== ~e.q) begin
          errors++;
          $display("FAIL %s ch%0d cyc=%0d q=%b q_n=%b expected q=%b q_n=%b",
                   e.req, e.ch, cyc, q[e.ch], q_n[e.ch], e.q, ~e.q);
        end
      end
    end
  end

  // Driver: update the reference from the inputs now applied, queue result, advance
  task automatic tick(int n);
    for (int k = 0; k < n; k++) begin
      for (int c = 0; c < NCH; c++) begin
        logic trig;
        int   d;
        exp_t e;
        d    = int'(dur[c*DUR_W +: DUR_W]);
        trig = (trig_b[c] && !pb[c] && !trig_a_n[c]) ||
               (pa_n[c] && !trig_a_n[c] && trig_b[c]) ||
               (clr_n[c] && !pclr[c] && !trig_a_n[c] && trig_b[c]);
        if (!clr_n[c])      m_cnt[c] = 0;
        else if (trig)      m_cnt[c] = d;
        else if (m_cnt[c] > 0) m_cnt[c] = m_cnt[c] - 1;
        e.tag = cyc + 3;
        e.ch  = c;
        e.q   = (m_cnt[c] > 0);
        e.req = phase;
        sb.push_back(e);
      end
      pa_n = trig_a_n; pb = trig_b; pclr = clr_n;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic set_dur(int c, int v);
    dur[c*DUR_W +: DUR_W] = DUR_W'(v);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) m_cnt[c] = 0;
    set_dur(0, 5);
    set_dur(1, 3);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    checks++;
    if (q !== '0 || q_n !== '1) begin
      errors++;
      $display("FAIL R1 after reset q=%b q_n=%b expected q=00 q_n=11", q, q_n);
    end
    started = 1;
    tick(4);

    // R2 / R5: B rises while A low
    phase = "R2";
    trig_a_n[0] = 1'b0; tick(2);
    trig_b[0] = 1'b1;   tick(9);
    phase = "R5";
    trig_b[0] = 1'b0;   tick(4);

    // R3: A falls while B high
    phase = "R3";
    trig_a_n[0] = 1'b1; tick(2);
    trig_b[0]   = 1'b1; tick(2);
    trig_a_n[0] = 1'b0; tick(10);

    // R12: unqualified edges
    phase = "R12";
    trig_a_n[0] = 1'b1; trig_b[0] = 1'b0; tick(3);
    trig_b[0] = 1'b1;   tick(6);   // B rises, A high
    trig_b[0] = 1'b0;   tick(2);
    trig_a_n[0] = 1'b0; tick(6);   // A falls, B low

    // R4 and R7 blocking: clear held low masks B rising, then release triggers
    phase = "R7";
    clr_n[0] = 1'b0; tick(2);
    trig_b[0] = 1'b1; tick(6);
    phase = "R4";
    clr_n[0] = 1'b1; tick(10);

    // R6: retrigger every 3 cycles with count 5
    phase = "R6";
    trig_b[0] = 1'b0; tick(2);
    for (int r = 0; r < 5; r++) begin
      trig_b[0] = 1'b1; tick(1);
      trig_b[0] = 1'b0; tick(2);
    end
    tick(8);

    // R6 boundary: retrigger on the last high cycle
    set_dur(0, 4); tick(3);
    trig_b[0] = 1'b1; tick(1);
    trig_b[0] = 1'b0; tick(3);
    trig_b[0] = 1'b1; tick(1);
    trig_b[0] = 1'b0; tick(8);

    // R7: clear cuts a running pulse
    phase = "R7";
    set_dur(0, 40); tick(3);
    trig_b[0] = 1'b1; tick(6);
    trig_b[0] = 1'b0; clr_n[0] = 1'b0; tick(5);
    clr_n[0] = 1'b1; tick(5);

    // R8: trigger and clear in the same cycle
    phase = "R8";
    set_dur(0, 5); tick(3);
    trig_b[0] = 1'b1; clr_n[0] = 1'b0; tick(6);
    trig_b[0] = 1'b0; tick(2);
    clr_n[0] = 1'b1; tick(5);

    // R9: zero count
    phase = "R9";
    set_dur(0, 0); tick(3);
    trig_b[0] = 1'b1; tick(3);
    trig_b[0] = 1'b0; tick(5);

    // R5: single-cycle pulse
    phase = "R5";
    set_dur(0, 1); tick(3);
    trig_b[0] = 1'b1; tick(3);
    trig_b[0] = 1'b0; tick(5);

    // R11: channel 1 pulses while channel 0 held cleared, then both at once
    phase = "R11";
    set_dur(0, 6); tick(3);
    clr_n[0] = 1'b0;
    trig_a_n[1] = 1'b0; tick(2);
    trig_b[1] = 1'b1;   tick(8);
    clr_n[0] = 1'b1; trig_b[0] = 1'b0; trig_b[1] = 1'b0; tick(2);
    trig_b[0] = 1'b1; trig_b[1] = 1'b1; tick(10);

    phase = "R10";
    tick(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired phase=%s actual=hung expected=finished", phase);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule